// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block is the host-side byte register port of a coprocessor board. Through eight byte-wide register offsets the host can hold the board's local processor in reset or halt and exchange interrupts with it in both directions. It can also read and write the board's local RAM without mapping that RAM into its own address space. Each host access is one strobe cycle: a 3-bit offset, a write or read strobe and a data byte.

Local RAM is reached indirectly. The host loads a 24-bit pointer one byte at a time, then moves data through one of two data windows. The plain window leaves the pointer where it is. The stepping window advances the pointer by one after every access, so a block transfer needs only repeated accesses to a single offset. The RAM itself sits behind a simple synchronous port with one cycle of read latency. Every host read returns its byte, marked valid, exactly one cycle after the read strobe.

The interrupt bits in the control byte behave differently on read and write. Board-to-host requests latch a pending flag, which the host clears by writing a one. Host-to-board requests are raised by a host write and drop when the board acknowledges them. A 3-bit select code chooses which host interrupt line the block reports.

Top module: `hostmem_port`

## Requirements
- R1: After reset the control byte reads 0x80 (processor held in reset, all other bits 0), the pointer reads 0, `cpu_reset` is 1 and `cpu_halt`, `host_irq`, `h2b_irq` and `rd_valid` are 0.
- R2: Offset 0 always reads 0xA1 and offset 7 always reads 0x00; writes to either leave every register unchanged.
- R3: Writing offset 1 loads control bit 7 (reset hold), bit 4 (halt hold), bit 3 (interrupt enable) and bits 2:0 (select code), all of which read back. Bit 7 drives `cpu_reset` and bit 4 drives `cpu_halt`.
- R4: Control bit 6 reads 1 while a board-to-host request is pending. A `brd_irq_req` pulse sets it. Writing offset 1 with bit 6 = 1 clears it, and writing 0 there does nothing. A request in the same cycle as a clear leaves the flag set.
- R5: Writing offset 1 with bit 5 = 1 raises `h2b_irq`, and control bit 5 reads 1 while it is raised. `brd_irq_ack` lowers it. A host raise in the same cycle as an acknowledge leaves it raised. Writing 0 to bit 5 has no effect.
- R6: `host_irq` is 1 exactly when the pending flag is set, the enable bit is set and the select code is nonzero.
- R7: `irq_line` reports the selected interrupt number: codes 0..7 map to 0, 3, 5, 7, 10, 11, 12, 15.
- R8: Offsets 2, 3 and 4 write and read pointer bits 7:0, 15:8 and 23:16 respectively.
- R9: A read or write through offset 5 leaves the pointer unchanged. One through offset 6 advances it by one after the access, and a result at or above RAM_BYTES (default 0x40000) becomes 0.
- R10: While the pointer is at or above RAM_BYTES, data window accesses start no memory cycle, and reads return 0x00.
- R11: Every host read strobe is followed in the next cycle by a one-cycle `rd_valid` carrying the read byte.
- R12: A data window write stores the host byte at the pointer address, and a later data window read at that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_off | input | 3 | Register offset of the host access |
| wr_stb | input | 1 | Host write strobe, one cycle per access |
| rd_stb | input | 1 | Host read strobe, one cycle per access |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, valid with rd_valid |
| rd_valid | output | 1 | Read response, one cycle after rd_stb |
| cpu_reset | output | 1 | Holds the local processor in reset |
| cpu_halt | output | 1 | Holds the local processor in halt |
| h2b_irq | output | 1 | Host-to-board interrupt request |
| brd_irq_req | input | 1 | Board-to-host interrupt request pulse |
| brd_irq_ack | input | 1 | Board has seen the host-to-board interrupt |
| host_irq | output | 1 | Board-to-host interrupt towards the host |
| irq_line | output | 4 | Selected host interrupt number |
| mem_en | output | 1 | Local RAM cycle enable |
| mem_we | output | 1 | Local RAM write enable |
| mem_addr | output | 18 | Local RAM byte address |
| mem_wdata | output | 8 | Local RAM write byte |
| mem_rdata | input | 8 | Local RAM read byte, one cycle after mem_en |

## Verification
The assertions check several rules on every cycle. They cover the set, clear and hold rules of both interrupt flags, including the same-cycle priorities, and the rule that raises `host_irq` after a request when the output is enabled. They also check that the pointer holds on the plain window, steps by one or wraps to zero on the stepping window, and that no memory cycle starts while the pointer is out of range. The response strobe arrives one cycle after each read. The bench's scenarios are needed for the rest: the read-back values of every offset, the select-code mapping, and the data round trips through RAM at the top address and across the wrap. They also show that an out-of-range write does not alias onto a low address and that writes to the fixed offsets change nothing.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

    localparam logic [2:0] OFF_ID   = 3'd0;
    localparam logic [2:0] OFF_CTRL = 3'd1;
    localparam logic [2:0] OFF_PLO  = 3'd2;
    localparam logic [2:0] OFF_PMID = 3'd3;
    localparam logic [2:0] OFF_PHI  = 3'd4;
    localparam logic [2:0] OFF_DATA = 3'd5;
    localparam logic [2:0] OFF_DINC = 3'd6;

    localparam logic [7:0] ID_VALUE = 8'hA1;
    localparam int         PTR_W    = 24;

    // control byte, bit 7 first
    typedef struct packed {
        logic       hold_rst;
        logic       b2h_pend;
        logic       h2b_req;
        logic       hold_halt;
        logic       irq_en;
        logic [2:0] irq_sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{hold_rst: 1'b1, b2h_pend: 1'b0, h2b_req: 1'b0,
                                     hold_halt: 1'b0, irq_en: 1'b0, irq_sel: 3'd0};

    function automatic logic [3:0] sel_to_line(input logic [2:0] sel);
        case (sel)
            3'd1:    return 4'd3;
            3'd2:    return 4'd5;
            3'd3:    return 4'd7;
            3'd4:    return 4'd10;
            3'd5:    return 4'd11;
            3'd6:    return 4'd12;
            3'd7:    return 4'd15;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/hmp_ctrl.sv
module hmp_ctrl
    import hmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata,
    input  logic       brd_irq_req,
    input  logic       brd_irq_ack,
    output ctrl_t      ctrl,
    output logic       host_irq,
    output logic [3:0] irq_line
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (brd_irq_ack) begin
            ctrl_d.h2b_req = 1'b0;
        end
        if (wr_ctrl) begin
            ctrl_d.hold_rst  = wdata[7];
            ctrl_d.hold_halt = wdata[4];
            ctrl_d.irq_en    = wdata[3];
            ctrl_d.irq_sel   = wdata[2:0];
            if (wdata[6]) begin
                ctrl_d.b2h_pend = 1'b0;
            end
            if (wdata[5]) begin
                ctrl_d.h2b_req = 1'b1;
            end
        end
        if (brd_irq_req) begin
            ctrl_d.b2h_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl     = ctrl_q;
    assign host_irq = ctrl_q.b2h_pend && ctrl_q.irq_en && (ctrl_q.irq_sel != 3'd0);
    assign irq_line = sel_to_line(ctrl_q.irq_sel);

    // R4: a clear without a competing request empties the flag
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[6] && !brd_irq_req) |=> !ctrl_q.b2h_pend);
    // R4: a request always lands, even against a clear
    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
        brd_irq_req |=> ctrl_q.b2h_pend);
    // R4: untouched flag holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ctrl && !brd_irq_req) |=> $stable(ctrl_q.b2h_pend));
    // R5: acknowledge drops the request unless the host raises it again
    a_r5_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_irq_ack && !(wr_ctrl && wdata[5])) |=> !ctrl_q.h2b_req);
    // R5: host raise wins
    a_r5_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[5]) |=> ctrl_q.h2b_req);
    // R6: an enabled, routed request reaches the host line
    a_r6_irq_out: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_irq_req && !wr_ctrl && ctrl_q.irq_en && ctrl_q.irq_sel != 3'd0) |=> host_irq);

endmodule

// File: rtl/hmp_pointer.sv
module hmp_pointer
    import hmp_pkg::*;
#(
    parameter int RAM_BYTES = 32'h40000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [2:0]       reg_off,
    input  logic [7:0]       wdata,
    output logic [PTR_W-1:0] ptr,
    output logic             in_range,
    output logic             data_acc
);

    localparam logic [PTR_W:0] RAM_LIM = (PTR_W + 1)'(RAM_BYTES);

    logic [PTR_W-1:0] ptr_d, ptr_q;
    logic [PTR_W:0]   ptr_inc;
    logic             step;

    always_comb begin
        data_acc = (wr_stb || rd_stb) && (reg_off == OFF_DATA || reg_off == OFF_DINC);
        step     = data_acc && (reg_off == OFF_DINC);
        ptr_inc  = {1'b0, ptr_q} + (PTR_W + 1)'(1);
        ptr_d    = ptr_q;
        if (wr_stb) begin
            case (reg_off)
                OFF_PLO:  ptr_d[7:0]   = wdata;
                OFF_PMID: ptr_d[15:8]  = wdata;
                OFF_PHI:  ptr_d[23:16] = wdata;
                default:  ;
            endcase
        end
        if (step) begin
            ptr_d = (ptr_inc >= RAM_LIM) ? '0 : ptr_inc[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr      = ptr_q;
    assign in_range = {1'b0, ptr_q} < RAM_LIM;

    // R9: plain window keeps the pointer
    a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_stb || rd_stb) && reg_off == OFF_DATA) |=> $stable(ptr_q));
    // R9: stepping window below the top advances by one
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ({1'b0, ptr_q} < RAM_LIM - 1)) |=> (ptr_q == $past(ptr_q) + 24'd1));
    // R9: stepping at or past the top lands on zero
    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ({1'b0, ptr_q} >= RAM_LIM - 1)) |=> (ptr_q == '0));

endmodule

// File: rtl/hmp_rdpath.sv
module hmp_rdpath
    import hmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic [2:0]       reg_off,
    input  ctrl_t            ctrl,
    input  logic [PTR_W-1:0] ptr,
    input  logic             in_range,
    input  logic [7:0]       mem_rdata,
    output logic [7:0]       rdata,
    output logic             rd_valid
);

    typedef struct packed {
        logic       valid;
        logic       from_mem;
        logic       oor;
        logic [7:0] snap;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d          = rsp_q;
        rsp_d.valid    = rd_stb;
        rsp_d.from_mem = 1'b0;
        rsp_d.oor      = 1'b0;
        if (rd_stb) begin
            rsp_d.from_mem = (reg_off == OFF_DATA) || (reg_off == OFF_DINC);
            rsp_d.oor      = !in_range;
            case (reg_off)
                OFF_ID:   rsp_d.snap = ID_VALUE;
                OFF_CTRL: rsp_d.snap = ctrl;
                OFF_PLO:  rsp_d.snap = ptr[7:0];
                OFF_PMID: rsp_d.snap = ptr[15:8];
                OFF_PHI:  rsp_d.snap = ptr[23:16];
                default:  rsp_d.snap = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_valid = rsp_q.valid;
    assign rdata    = rsp_q.from_mem ? (rsp_q.oor ? 8'h00 : mem_rdata) : rsp_q.snap;

    // R11: every read strobe yields a response next cycle, and only then
    a_r11_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);
    a_r11_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);

endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
    import hmp_pkg::*;
#(
    parameter int RAM_BYTES = 32'h40000,
    localparam int MEM_AW   = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_off,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rd_valid,
    output logic              cpu_reset,
    output logic              cpu_halt,
    output logic              h2b_irq,
    input  logic              brd_irq_req,
    input  logic              brd_irq_ack,
    output logic              host_irq,
    output logic [3:0]        irq_line,
    output logic              mem_en,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    ctrl_t            ctrl;
    logic [PTR_W-1:0] ptr;
    logic             in_range;
    logic             data_acc;

    hmp_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_stb && reg_off == OFF_CTRL),
        .wdata       (wdata),
        .brd_irq_req (brd_irq_req),
        .brd_irq_ack (brd_irq_ack),
        .ctrl        (ctrl),
        .host_irq    (host_irq),
        .irq_line    (irq_line)
    );

    hmp_pointer #(.RAM_BYTES(RAM_BYTES)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .reg_off  (reg_off),
        .wdata    (wdata),
        .ptr      (ptr),
        .in_range (in_range),
        .data_acc (data_acc)
    );

    hmp_rdpath u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .reg_off   (reg_off),
        .ctrl      (ctrl),
        .ptr       (ptr),
        .in_range  (in_range),
        .mem_rdata (mem_rdata),
        .rdata     (rdata),
        .rd_valid  (rd_valid)
    );

    assign cpu_reset = ctrl.hold_rst;
    assign cpu_halt  = ctrl.hold_halt;
    assign h2b_irq   = ctrl.h2b_req;

    assign mem_en    = data_acc && in_range;
    assign mem_we    = mem_en && wr_stb;
    assign mem_addr  = ptr[MEM_AW-1:0];
    assign mem_wdata = wdata;

    // R10: an out-of-range pointer never starts a memory cycle
    a_r10_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_stb || rd_stb) && !in_range) |-> !mem_en);
    // R12: a data window write reaches memory when in range
    a_r12_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && in_range && (reg_off == OFF_DATA || reg_off == OFF_DINC)) |-> mem_we);

endmodule

// File: tb/hostmem_port_tb.sv
`timescale 1ns/1ps
module hostmem_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_off = '0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rd_valid;
    logic        cpu_reset, cpu_halt, h2b_irq, host_irq;
    logic        brd_irq_req = 1'b0;
    logic        brd_irq_ack = 1'b0;
    logic [3:0]  irq_line;
    logic        mem_en, mem_we;
    logic [17:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int mem_cnt = 0;
    logic [7:0] ram [int];

    always #10 clk = ~clk;

    hostmem_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .cpu_reset(cpu_reset),
        .cpu_halt(cpu_halt), .h2b_irq(h2b_irq), .brd_irq_req(brd_irq_req),
        .brd_irq_ack(brd_irq_ack), .host_irq(host_irq), .irq_line(irq_line),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // synchronous RAM model, one cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            mem_cnt = mem_cnt + 1;
            if (mem_we) ram[int'(mem_addr)] = mem_wdata;
            else mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        reg_off = off; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] off, output logic [7:0] d);
        @(negedge clk);
        reg_off = off; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R11 rd_valid", {31'd0, rd_valid}, 32'd1);
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] off, input logic [7:0] exp);
        logic [7:0] v;
        hrd(off, v);
        check(req, {24'd0, v}, {24'd0, exp});
    endtask

    task automatic set_ptr(input logic [23:0] p);
        hwr(3'd2, p[7:0]);
        hwr(3'd3, p[15:8]);
        hwr(3'd4, p[23:16]);
    endtask

    function automatic logic [3:0] exp_line(input int s);
        int nums [8] = '{0, 3, 5, 7, 10, 11, 12, 15};
        return 4'(nums[s]);
    endfunction

    // vector: is_rd, offset, data (write) or expected (read), requirement number
    typedef struct packed {
        logic       is_rd;
        logic [2:0] off;
        logic [7:0] dat;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd2, 8'h10, 4'd8},   // R8 pointer low
        '{1'b0, 3'd3, 8'h00, 4'd8},   // R8 pointer mid
        '{1'b0, 3'd4, 8'h00, 4'd8},   // R8 pointer high
        '{1'b1, 3'd2, 8'h10, 4'd8},   // R8 readback
        '{1'b0, 3'd6, 8'hAA, 4'd12},  // R12 write, step
        '{1'b0, 3'd6, 8'hBB, 4'd12},  // R12 write, step
        '{1'b1, 3'd2, 8'h12, 4'd9},   // R9 two steps
        '{1'b0, 3'd2, 8'h10, 4'd8},   // R8 rewind
        '{1'b1, 3'd5, 8'hAA, 4'd12},  // R12 plain read
        '{1'b1, 3'd5, 8'hAA, 4'd9},   // R9 plain window keeps pointer
        '{1'b1, 3'd6, 8'hAA, 4'd12},  // R12 stepping read
        '{1'b1, 3'd6, 8'hBB, 4'd12},  // R12 stepping read
        '{1'b1, 3'd2, 8'h12, 4'd9},   // R9 read steps
        '{1'b1, 3'd0, 8'hA1, 4'd2},   // R2 identification
        '{1'b1, 3'd7, 8'h00, 4'd2},   // R2 unused offset
        '{1'b0, 3'd1, 8'h9B, 4'd3},   // R3 control load
        '{1'b1, 3'd1, 8'h9B, 4'd3},   // R3 control readback
        '{1'b0, 3'd1, 8'h00, 4'd3}    // R3 control clear
    };

    bit done = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cpu_reset", {31'd0, cpu_reset}, 32'd1);
        check("R1 cpu_halt", {31'd0, cpu_halt}, 32'd0);
        check("R1 host_irq", {31'd0, host_irq}, 32'd0);
        check("R1 h2b_irq", {31'd0, h2b_irq}, 32'd0);
        check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        rd_chk("R1 control", 3'd1, 8'h80);
        rd_chk("R1 ptr lo", 3'd2, 8'h00);
        rd_chk("R1 ptr mid", 3'd3, 8'h00);
        rd_chk("R1 ptr hi", 3'd4, 8'h00);
        @(negedge clk);
        check("R11 single pulse", {31'd0, rd_valid}, 32'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                hrd(VECS[i].off, v);
                total++;
                if (v !== VECS[i].dat) begin
                    bad++;
                    $display("FAIL R%0d vec %0d: got 0x%0h expected 0x%0h",
                             VECS[i].req, i, v, VECS[i].dat);
                end
            end else begin
                hwr(VECS[i].off, VECS[i].dat);
            end
        end

        // R3 outputs
        hwr(3'd1, 8'h90);
        check("R3 cpu_reset", {31'd0, cpu_reset}, 32'd1);
        check("R3 cpu_halt", {31'd0, cpu_halt}, 32'd1);
        hwr(3'd1, 8'h00);
        check("R3 cpu_reset off", {31'd0, cpu_reset}, 32'd0);
        check("R3 cpu_halt off", {31'd0, cpu_halt}, 32'd0);

        // R7 select mapping
        for (int s = 0; s < 8; s++) begin
            hwr(3'd1, 8'h08 | 8'(s));
            check("R7 irq_line", {28'd0, irq_line}, {28'd0, exp_line(s)});
        end

        // R4 / R6 board-to-host
        hwr(3'd1, 8'h0A);
        check("R6 idle", {31'd0, host_irq}, 32'd0);
        @(negedge clk); brd_irq_req = 1'b1;
        @(negedge clk); brd_irq_req = 1'b0;
        check("R6 raised", {31'd0, host_irq}, 32'd1);
        rd_chk("R4 pending", 3'd1, 8'h4A);
        hwr(3'd1, 8'h02);
        check("R6 disabled", {31'd0, host_irq}, 32'd0);
        rd_chk("R4 write 0 keeps", 3'd1, 8'h42);
        hwr(3'd1, 8'h08);
        check("R6 no line", {31'd0, host_irq}, 32'd0);
        hwr(3'd1, 8'h4A);
        rd_chk("R4 cleared", 3'd1, 8'h0A);
        check("R6 cleared", {31'd0, host_irq}, 32'd0);
        @(negedge clk);
        reg_off = 3'd1; wdata = 8'h4A; wr_stb = 1'b1; brd_irq_req = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; brd_irq_req = 1'b0;
        rd_chk("R4 set beats clear", 3'd1, 8'h4A);
        check("R6 after race", {31'd0, host_irq}, 32'd1);
        hwr(3'd1, 8'h40);

        // R5 host-to-board
        hwr(3'd1, 8'h20);
        check("R5 raised", {31'd0, h2b_irq}, 32'd1);
        rd_chk("R5 bit reads 1", 3'd1, 8'h20);
        hwr(3'd1, 8'h00);
        check("R5 write 0 keeps", {31'd0, h2b_irq}, 32'd1);
        @(negedge clk); brd_irq_ack = 1'b1;
        @(negedge clk); brd_irq_ack = 1'b0;
        check("R5 acked", {31'd0, h2b_irq}, 32'd0);
        rd_chk("R5 bit reads 0", 3'd1, 8'h00);
        @(negedge clk);
        reg_off = 3'd1; wdata = 8'h20; wr_stb = 1'b1; brd_irq_ack = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; brd_irq_ack = 1'b0;
        check("R5 raise beats ack", {31'd0, h2b_irq}, 32'd1);
        @(negedge clk); brd_irq_ack = 1'b1;
        @(negedge clk); brd_irq_ack = 1'b0;

        // R2 writes to fixed offsets ignored
        hwr(3'd0, 8'h55);
        hwr(3'd7, 8'h66);
        rd_chk("R2 id after write", 3'd0, 8'hA1);
        rd_chk("R2 off7 after write", 3'd7, 8'h00);
        rd_chk("R2 control untouched", 3'd1, 8'h00);
        rd_chk("R2 ptr untouched", 3'd2, 8'h12);

        // R9 wrap at the top, R12 top address round trip
        set_ptr(24'h03FFFF);
        hwr(3'd6, 8'h5C);
        rd_chk("R9 wrap lo", 3'd2, 8'h00);
        rd_chk("R9 wrap mid", 3'd3, 8'h00);
        rd_chk("R9 wrap hi", 3'd4, 8'h00);
        set_ptr(24'h03FFFF);
        rd_chk("R12 top byte", 3'd5, 8'h5C);
        rd_chk("R9 keep after plain read", 3'd2, 8'hFF);

        // R10 out of range
        set_ptr(24'h000000);
        hwr(3'd5, 8'h11);
        hwr(3'd4, 8'h04);
        c0 = mem_cnt;
        hwr(3'd5, 8'h77);
        rd_chk("R10 read zero", 3'd5, 8'h00);
        check("R10 no memory cycle", 32'(mem_cnt), 32'(c0));
        hwr(3'd6, 8'h78);
        rd_chk("R9 step from out of range", 3'd4, 8'h00);
        rd_chk("R10 no alias", 3'd5, 8'h11);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule